// File: doc/BRIEF.md
# Tiled Image Address Generator

The block walks a rectangular image of elements (pixels, or whole compressed blocks) in plain raster order: x runs fastest, then y. For every element it emits the coordinates together with the byte offset at which that element lives in a tiled memory layout. Memory is organised as square tiles stored one after another in row-major tile order. Inside a tile, elements follow an interleaved space-filling curve whose bit pairs are XORed. The element contents are never touched, so the mapping works for any element size.

A pulse on `start` loads the image width, height, bytes per element and tiling mode. The generator then presents one element per cycle on a valid/ready stream. The consumer can stall it at any time without losing or repeating an element. After the last element has been accepted, `done` pulses for one cycle. Regular mode uses 16x16-element tiles. Block mode uses 4x4 tiles of whole blocks, which for 4x4 compressed formats gives an effective 16x16-pixel tiling. Tiles that run past the right or bottom edge are padded: their missing elements are never emitted, but they still take up their full space in the offsets.

Top module: `tile_addr_gen`

## Requirements
- R1: While reset is held, and in the cycle after it is released, `out_valid` and `done` are both low.
- R2: A frame starts at (0,0). It visits every element with x < width and y < height exactly once, with x incrementing fastest and wrapping to 0 as y increments. No element outside the image is ever emitted.
- R3: In regular mode (`blk_mode`=0) the tile edge is 16. Let lx = x mod 16 and ly = y mod 16. The intra-tile index, from bit 7 down to bit 0, is ly[3], lx[3]^ly[3], ly[2], lx[2]^ly[2], ly[1], lx[1]^ly[1], ly[0], lx[0]^ly[0].
- R4: In block mode (`blk_mode`=1) the tile edge is 4. The intra-tile index is a 4-bit value: from bit 3 down to bit 0 it is ly[1], lx[1]^ly[1], ly[0], lx[0]^ly[0], with lx = x mod 4 and ly = y mod 4.
- R5: Tiles are stored in row-major order, and each tile row holds ceil(width/edge) tiles, partial tiles included. The element index is (tile_row*tiles_per_row + tile_col)*edge*edge + intra index.
- R6: `out_ofs` equals the element index multiplied by the bytes-per-element value captured at start.
- R7: While `out_valid` is high and `out_ready` is low, `out_x`, `out_y` and `out_ofs` hold their values and `out_valid` stays high.
- R8: `done` goes high for exactly one cycle, in the cycle after the last element is accepted, and `out_valid` is low in that cycle.
- R9: A `start` pulse during a frame is ignored. The running frame continues with its original dimensions, mode and element size, which were captured at start.
- R10: A start with a width or height of zero emits no element and raises `done` in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a frame (used only while no frame is streaming) |
| img_w | input | DIM_W | Image width in elements |
| img_h | input | DIM_W | Image height in elements |
| elem_bytes | input | BPE_W | Bytes per element |
| blk_mode | input | 1 | 0 = 16x16 tiles, 1 = 4x4 block tiles |
| out_ready | input | 1 | Consumer accepts the current element |
| out_valid | output | 1 | Current element is valid |
| out_x | output | DIM_W | Element column |
| out_y | output | DIM_W | Element row |
| out_ofs | output | OFS_W | Byte offset in the tiled layout |
| done | output | 1 | One-cycle pulse after the last element is accepted |

## Verification
The bench uses the default parameters: 12-bit dimensions, 5-bit element size and 40-bit offsets. Image sizes stay below about 80 elements per side, which keeps runs short while still covering several tile columns and rows, partial tiles on both edges in both modes, and widths that are not a multiple of the tile edge. Element sizes from 1 to 16 bytes check the scaling, and random backpressure, including long stalls, checks that elements are held and never repeated.

// File: rtl/tile_pkg.sv
package tile_pkg;
  localparam int REG_EDGE_LOG = 4;
  localparam int BLK_EDGE_LOG = 2;
  localparam int IDX_W        = 2 * REG_EDGE_LOG;

  typedef enum logic {
    TILE_REGULAR = 1'b0,
    TILE_BLOCK   = 1'b1
  } tile_mode_e;
endpackage

// File: rtl/tile_swizzle.sv
module tile_swizzle #(
  parameter int PAIRS = 4
) (
  input  logic [PAIRS-1:0]   lx,
  input  logic [PAIRS-1:0]   ly,
  output logic [2*PAIRS-1:0] idx
);
  for (genvar i = 0; i < PAIRS; i++) begin : g_pair
    assign idx[2*i+1] = ly[i];
    assign idx[2*i]   = lx[i] ^ ly[i];
  end
endmodule

// File: rtl/raster_walker.sv
module raster_walker #(
  parameter int DIM_W = 12
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic [DIM_W-1:0] img_w,
  input  logic [DIM_W-1:0] img_h,
  input  logic             ready,
  output logic             valid,
  output logic [DIM_W-1:0] x,
  output logic [DIM_W-1:0] y,
  output logic             done,
  output logic             launch,
  output logic             load_first,
  output logic             advance,
  output logic [DIM_W-1:0] nxt_x,
  output logic [DIM_W-1:0] nxt_y
);
  logic [DIM_W-1:0] w_q, h_q;
  logic             row_end, last, nonzero;

  assign launch     = start && !valid;
  assign nonzero    = (img_w != '0) && (img_h != '0);
  assign load_first = launch && nonzero;
  assign row_end    = (x == w_q - 1'b1);
  assign last       = row_end && (y == h_q - 1'b1);
  assign advance    = valid && ready && !last;
  assign nxt_x      = row_end ? '0 : x + 1'b1;
  assign nxt_y      = row_end ? y + 1'b1 : y;

  always_ff @(posedge clk) begin
    if (rst) begin
      valid <= 1'b0;
      done  <= 1'b0;
      x     <= '0;
      y     <= '0;
      w_q   <= '0;
      h_q   <= '0;
    end else begin
      done <= 1'b0;
      if (launch) begin
        w_q <= img_w;
        h_q <= img_h;
        x   <= '0;
        y   <= '0;
        if (nonzero) valid <= 1'b1;
        else         done  <= 1'b1;
      end else if (valid && ready) begin
        if (last) begin
          valid <= 1'b0;
          done  <= 1'b1;
        end else begin
          x <= nxt_x;
          y <= nxt_y;
        end
      end
    end
  end

  p_stall_hold_r7: assert property (@(posedge clk) disable iff (rst)
    valid && !ready |=> valid && $stable(x) && $stable(y));
  p_done_single_r8: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
  p_done_idle_r8: assert property (@(posedge clk) disable iff (rst)
    done |-> !valid);
  p_in_bounds_r2: assert property (@(posedge clk) disable iff (rst)
    valid |-> (x < w_q) && (y < h_q));
endmodule

// File: rtl/tile_offset_calc.sv
module tile_offset_calc
  import tile_pkg::*;
#(
  parameter int DIM_W = 12,
  parameter int BPE_W = 5,
  parameter int OFS_W = 40
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load_first,
  input  logic             load_next,
  input  logic [DIM_W-1:0] nxt_x,
  input  logic [DIM_W-1:0] nxt_y,
  input  logic [DIM_W-1:0] cfg_w,
  input  logic [BPE_W-1:0] cfg_bpe,
  input  tile_mode_e       cfg_mode,
  output logic [OFS_W-1:0] ofs_q
);
  localparam int LIN_W = 2 * DIM_W + 1;

  logic                     blk;
  logic [DIM_W:0]           w_ext, tpr;
  logic [DIM_W-1:0]         t_row, t_col;
  logic [REG_EDGE_LOG-1:0]  lx, ly;
  logic [IDX_W-1:0]         intra;
  logic [LIN_W-1:0]         tile_lin;
  logic [OFS_W-1:0]         lin_w, elem_idx, ofs_d;

  assign blk   = (cfg_mode == TILE_BLOCK);
  assign w_ext = {1'b0, cfg_w};
  assign tpr   = blk ? ((w_ext + (DIM_W+1)'(3))  >> BLK_EDGE_LOG)
                     : ((w_ext + (DIM_W+1)'(15)) >> REG_EDGE_LOG);
  assign t_row = blk ? (nxt_y >> BLK_EDGE_LOG) : (nxt_y >> REG_EDGE_LOG);
  assign t_col = blk ? (nxt_x >> BLK_EDGE_LOG) : (nxt_x >> REG_EDGE_LOG);
  assign lx    = blk ? {2'b00, nxt_x[1:0]} : nxt_x[REG_EDGE_LOG-1:0];
  assign ly    = blk ? {2'b00, nxt_y[1:0]} : nxt_y[REG_EDGE_LOG-1:0];

  tile_swizzle #(.PAIRS(REG_EDGE_LOG)) u_swz (
    .lx  (lx),
    .ly  (ly),
    .idx (intra)
  );

  assign tile_lin = LIN_W'(t_row) * LIN_W'(tpr) + LIN_W'(t_col);
  assign lin_w    = OFS_W'(tile_lin);
  assign elem_idx = blk ? ((lin_w << (2*BLK_EDGE_LOG)) | OFS_W'(intra))
                        : ((lin_w << (2*REG_EDGE_LOG)) | OFS_W'(intra));
  assign ofs_d    = elem_idx * OFS_W'(cfg_bpe);

  always_ff @(posedge clk) begin
    if (rst)             ofs_q <= '0;
    else if (load_first) ofs_q <= '0;
    else if (load_next)  ofs_q <= ofs_d;
  end

  always_comb begin
    if (blk) a_blk_idx_r4: assert (intra < 16);
  end
endmodule

// File: rtl/tile_addr_gen.sv
module tile_addr_gen
  import tile_pkg::*;
#(
  parameter int DIM_W = 12,
  parameter int BPE_W = 5,
  parameter int OFS_W = 40
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic [DIM_W-1:0] img_w,
  input  logic [DIM_W-1:0] img_h,
  input  logic [BPE_W-1:0] elem_bytes,
  input  logic             blk_mode,
  input  logic             out_ready,
  output logic             out_valid,
  output logic [DIM_W-1:0] out_x,
  output logic [DIM_W-1:0] out_y,
  output logic [OFS_W-1:0] out_ofs,
  output logic             done
);
  logic             launch, load_first, advance;
  logic [DIM_W-1:0] nxt_x, nxt_y;
  logic [DIM_W-1:0] cfg_w;
  logic [BPE_W-1:0] cfg_bpe;
  tile_mode_e       cfg_mode;

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_w    <= '0;
      cfg_bpe  <= '0;
      cfg_mode <= TILE_REGULAR;
    end else if (launch) begin
      cfg_w    <= img_w;
      cfg_bpe  <= elem_bytes;
      cfg_mode <= tile_mode_e'(blk_mode);
    end
  end

  raster_walker #(.DIM_W(DIM_W)) u_walk (
    .clk        (clk),
    .rst        (rst),
    .start      (start),
    .img_w      (img_w),
    .img_h      (img_h),
    .ready      (out_ready),
    .valid      (out_valid),
    .x          (out_x),
    .y          (out_y),
    .done       (done),
    .launch     (launch),
    .load_first (load_first),
    .advance    (advance),
    .nxt_x      (nxt_x),
    .nxt_y      (nxt_y)
  );

  tile_offset_calc #(.DIM_W(DIM_W), .BPE_W(BPE_W), .OFS_W(OFS_W)) u_ofs (
    .clk        (clk),
    .rst        (rst),
    .load_first (load_first),
    .load_next  (advance),
    .nxt_x      (nxt_x),
    .nxt_y      (nxt_y),
    .cfg_w      (cfg_w),
    .cfg_bpe    (cfg_bpe),
    .cfg_mode   (cfg_mode),
    .ofs_q      (out_ofs)
  );

  p_ofs_hold_r7: assert property (@(posedge clk) disable iff (rst)
    out_valid && !out_ready |=> $stable(out_ofs));
  p_first_origin_r5: assert property (@(posedge clk) disable iff (rst)
    $rose(out_valid) |-> (out_ofs == '0) && (out_x == '0) && (out_y == '0));
  p_busy_start_r9: assert property (@(posedge clk) disable iff (rst)
    out_valid && start && !out_ready |=> out_valid && $stable(out_x) && $stable(out_y));
endmodule

// File: tb/tb_tile_addr_gen.sv
module tb_tile_addr_gen;
  localparam int CLK_PERIOD = 10;
  localparam int DIM_W = 12;
  localparam int BPE_W = 5;
  localparam int OFS_W = 40;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             start = 1'b0;
  logic [DIM_W-1:0] img_w = '0, img_h = '0;
  logic [BPE_W-1:0] elem_bytes = '0;
  logic             blk_mode = 1'b0;
  logic             out_ready = 1'b0;
  logic             out_valid, done;
  logic [DIM_W-1:0] out_x, out_y;
  logic [OFS_W-1:0] out_ofs;

  int n_tests = 0;
  int n_fail  = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  tile_addr_gen #(.DIM_W(DIM_W), .BPE_W(BPE_W), .OFS_W(OFS_W)) dut (
    .clk(clk), .rst(rst), .start(start), .img_w(img_w), .img_h(img_h),
    .elem_bytes(elem_bytes), .blk_mode(blk_mode), .out_ready(out_ready),
    .out_valid(out_valid), .out_x(out_x), .out_y(out_y), .out_ofs(out_ofs),
    .done(done)
  );

  function automatic longint exp_ofs(int x, int y, int w, bit blk, int bpe);
    int ts = blk ? 2 : 4;
    int edge_n = 1 << ts;
    int tpr = (w + edge_n - 1) / edge_n;
    int lx = x % edge_n, ly = y % edge_n;
    longint idx = 0;
    for (int i = 0; i < ts; i++) begin
      idx |= longint'((ly >> i) & 1) << (2*i + 1);
      idx |= longint'(((lx >> i) ^ (ly >> i)) & 1) << (2*i);
    end
    return (longint'((y / edge_n) * tpr + (x / edge_n)) * edge_n * edge_n + idx) * bpe;
  endfunction

  task automatic check(bit ok, string req, string what, longint act, longint exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic run_frame(int w, int h, int bpe, bit blk, int stall_pct, bit poke);
    int idx = 0;
    int guard = 0;
    bit prev_stall = 0;
    logic [DIM_W-1:0] sx = '0, sy = '0;
    logic [OFS_W-1:0] so = '0;
    bit rdy;
    @(negedge clk);
    img_w = DIM_W'(w); img_h = DIM_W'(h); elem_bytes = BPE_W'(bpe);
    blk_mode = blk; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    // scramble inputs: the frame must keep its captured config (R9)
    img_w = DIM_W'(w + 7); img_h = '0; elem_bytes = BPE_W'(bpe + 3); blk_mode = ~blk;
    while (idx < w*h && guard < 40000) begin
      guard++;
      rdy = ($urandom_range(99) >= stall_pct);
      out_ready = rdy;
      start = poke && (idx == (w*h)/2);
      if (prev_stall)
        check(out_valid && out_x == sx && out_y == sy && out_ofs == so, "R7",
              "stall hold", longint'(out_ofs), longint'(so));
      if (!out_valid) begin
        check(0, "R2", "valid missing at element", idx, 1);
      end else begin
        check(out_x == DIM_W'(idx % w) && out_y == DIM_W'(idx / w), "R2",
              "raster xy", longint'(out_y) * 10000 + out_x,
              longint'(idx / w) * 10000 + idx % w);
        check(out_ofs == OFS_W'(exp_ofs(idx % w, idx / w, w, blk, bpe)),
              blk ? "R4/R5/R6" : "R3/R5/R6", "offset",
              longint'(out_ofs), exp_ofs(idx % w, idx / w, w, blk, bpe));
        check(!done, "R8", "done during frame", done, 0);
        prev_stall = !rdy;
        sx = out_x; sy = out_y; so = out_ofs;
        if (rdy) idx++;
      end
      @(negedge clk);
      start = 1'b0;
    end
    out_ready = 1'b0;
    check(done && !out_valid, "R8", "done after last", {done, out_valid}, 2);
    @(negedge clk);
    check(!done && !out_valid, "R8", "done single pulse", {done, out_valid}, 0);
  endtask

  initial begin
    #(CLK_PERIOD * 190000);
    n_fail++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    @(negedge clk);
    check(!out_valid && !done, "R1", "in reset", {out_valid, done}, 0);
    @(negedge clk); @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check(!out_valid && !done, "R1", "after reset", {out_valid, done}, 0);

    run_frame(16, 16, 4, 1'b0, 0, 1'b0);    // R3 one full tile
    run_frame(70, 3, 4, 1'b0, 30, 1'b1);    // R5 partial tiles, R9 busy start
    run_frame(5, 6, 8, 1'b1, 40, 1'b0);     // R4 block mode padded
    run_frame(1, 1, 1, 1'b0, 0, 1'b0);      // R2 single element
    run_frame(33, 2, 16, 1'b0, 80, 1'b0);   // R7 heavy stalls
    run_frame(9, 9, 3, 1'b1, 20, 1'b1);     // R6 odd size

    // R10: zero width
    @(negedge clk);
    img_w = '0; img_h = DIM_W'(5); start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check(done && !out_valid, "R10", "zero width", {done, out_valid}, 2);
    @(negedge clk);
    check(!done && !out_valid, "R10", "zero width after", {done, out_valid}, 0);
    // R10: zero height
    img_w = DIM_W'(4); img_h = '0; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check(done && !out_valid, "R10", "zero height", {done, out_valid}, 2);

    for (int k = 0; k < 8; k++) begin
      run_frame($urandom_range(40, 1), $urandom_range(40, 1), $urandom_range(16, 1),
                1'($urandom_range(1)), $urandom_range(60), 1'($urandom_range(1)));
    end

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule